// File: doc/BRIEF.md
# Load-Use Stall and Bubble Controller

This block holds the front three pipeline registers of a five-stage in-order pipeline (Fetch, Decode, Execute) and the hazard logic that guards them. Each register carries three register numbers, a memory-to-register flag and a few control bits. When the instruction in Execute is a load and its destination matches a source of the instruction in Decode, the block freezes Fetch and Decode for one cycle and clears Execute. A no-op bubble then travels down the pipeline instead of the dependent instruction.

A load's data is only known at the end of Memory, so the consumer cannot take it by forwarding into Execute on the next cycle. The one-cycle hold places the consumer in Execute when the load sits in Writeback, where a forwarding path outside this block can supply the value. The block also carries a small tail through Memory and Writeback, holding the destination and the write enables, so the bubble can be observed reaching the end of the pipe without writing anything.

Top module: `hzd_stall_top`

## Requirements
- R1: After reset, every pipeline register (Fetch, Decode, Execute, Memory, Writeback) holds the all-zero bubble encoding and the three strobes are low.
- R2: When Execute holds an instruction with memory-to-register set and a nonzero destination equal to the Decode first source (srcA), `stallFetch`, `stallDecode` and `flushExec` are all high in that same cycle.
- R3: The same stall is raised when the match is on the Decode second source (srcB).
- R4: An instruction in Execute with memory-to-register clear never causes a stall, even when it writes a register that Decode reads.
- R5: A load whose destination is register 0 never causes a stall, even when Decode reads register 0.
- R6: At a clock edge where the stall is high, the Fetch and Decode registers keep their contents and the instruction offered at the input is not captured.
- R7: At a clock edge where the flush is high, every field of the Execute register becomes zero.
- R8: The bubble reaches Memory one cycle after the flush and Writeback one cycle later, with both its register-write and memory-write enables low.
- R9: A stall lasts exactly one cycle. In the next cycle the dependent instruction moves into Execute while the load sits in Writeback, showing its destination and register-write enable.
- R10: No stall is raised when Execute holds a load whose destination matches neither Decode source.
- R11: Stage words use this bit layout (22 bits with defaults): srcA [21:17], srcB [16:12], dest [11:7], memory-to-register [6], register-write [5], memory-write [4], ALU operation [3:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inSrcA | input | 5 | First source register of the incoming instruction |
| inSrcB | input | 5 | Second source register of the incoming instruction |
| inDest | input | 5 | Destination register of the incoming instruction |
| inMemToReg | input | 1 | Incoming instruction is a load |
| inRegWrite | input | 1 | Incoming instruction writes a register |
| inMemWrite | input | 1 | Incoming instruction writes memory |
| inAluOp | input | 4 | ALU operation code of the incoming instruction |
| stallFetch | output | 1 | Fetch register hold strobe |
| stallDecode | output | 1 | Decode register hold strobe |
| flushExec | output | 1 | Execute register clear strobe |
| fetchWord | output | 22 | Fetch register contents (layout per R11) |
| decodeWord | output | 22 | Decode register contents (layout per R11) |
| execWord | output | 22 | Execute register contents (layout per R11) |
| memRegWrite | output | 1 | Register-write enable in the Memory stage |
| memMemWrite | output | 1 | Memory-write enable in the Memory stage |
| wbRegWrite | output | 1 | Register-write enable in the Writeback stage |
| wbDest | output | 5 | Destination register in the Writeback stage |

## Verification
Holding Fetch and Decode and clearing Execute happen at the same clock edge. The bench provokes this by sending a load and, right behind it, an instruction that reads the load's destination. A third instruction is already waiting at the input. After that edge it checks that Fetch still shows the third instruction, Decode still shows the consumer, and Execute reads all zero. It then follows the next two edges to confirm that the consumer enters Execute while the load is in Writeback, and that the bubble leaves Memory and Writeback with no write enable set.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  parameter int REG_W   = 5;
  parameter int OP_W    = 4;
  parameter int NUM_SRC = 2;
  parameter int TAIL_N  = 2;

  typedef struct packed {
    logic [REG_W-1:0] srcA;
    logic [REG_W-1:0] srcB;
    logic [REG_W-1:0] dest;
    logic             memToReg;
    logic             regWrite;
    logic             memWrite;
    logic [OP_W-1:0]  aluOp;
  } stage_t;

  localparam int STAGE_W = $bits(stage_t);

  typedef struct packed {
    logic holdFetch;
    logic holdDecode;
    logic clearExec;
  } strobe_t;

  typedef struct packed {
    logic [REG_W-1:0] dest;
    logic             regWrite;
    logic             memWrite;
  } tail_t;

endpackage

// File: rtl/hzd_detect.sv
module hzd_detect
  import hzd_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [REG_W-1:0]                exeDest,
  input  logic                            exeMemToReg,
  input  logic [NUM_SRC-1:0][REG_W-1:0]   decSrc,
  output strobe_t                         strobe
);

  logic [NUM_SRC-1:0] srcHit;
  logic               destLive;
  logic               loadUse;

  assign destLive = (exeDest != '0);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SRC; gi++) begin : g_cmp
      assign srcHit[gi] = (decSrc[gi] == exeDest);
    end
  endgenerate

  assign loadUse = exeMemToReg && destLive && (|srcHit);

  always_comb begin
    strobe.holdFetch  = loadUse;
    strobe.holdDecode = loadUse;
    strobe.clearExec  = loadUse;
  end

  AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.holdDecode |=> !strobe.holdDecode); // R9

endmodule

// File: rtl/hzd_pipe_regs.sv
module hzd_pipe_regs
  import hzd_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  stage_t  inStage,
  input  strobe_t strobe,
  output stage_t  fetchQ,
  output stage_t  decQ,
  output stage_t  exeQ,
  output tail_t   memQ,
  output tail_t   wbQ
);

  tail_t tailQ [TAIL_N];
  tail_t exeTail;

  always_ff @(posedge clk) begin
    if (!rst_n)                fetchQ <= '0;
    else if (!strobe.holdFetch) fetchQ <= inStage;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 decQ <= '0;
    else if (!strobe.holdDecode) decQ <= fetchQ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                exeQ <= '0;
    else if (strobe.clearExec) exeQ <= '0;
    else                       exeQ <= decQ;
  end

  always_comb begin
    exeTail.dest     = exeQ.dest;
    exeTail.regWrite = exeQ.regWrite;
    exeTail.memWrite = exeQ.memWrite;
  end

  genvar gt;
  generate
    for (gt = 0; gt < TAIL_N; gt++) begin : g_tail
      if (gt == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) tailQ[gt] <= '0;
          else        tailQ[gt] <= exeTail;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) tailQ[gt] <= '0;
          else        tailQ[gt] <= tailQ[gt-1];
        end
      end
    end
  endgenerate

  assign memQ = tailQ[0];
  assign wbQ  = tailQ[TAIL_N-1];

  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.holdFetch |=> (fetchQ == $past(fetchQ))); // R6

  AST_DECODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.holdDecode |=> (decQ == $past(decQ))); // R6

  AST_EXEC_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.clearExec |=> (exeQ == '0)); // R7

  AST_MEM_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.clearExec |=> ##1 (!memQ.regWrite && !memQ.memWrite)); // R8

  AST_STALL_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.holdDecode |-> exeQ.memToReg); // R4

endmodule

// File: rtl/hzd_stall_top.sv
module hzd_stall_top
  import hzd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [REG_W-1:0]   inSrcA,
  input  logic [REG_W-1:0]   inSrcB,
  input  logic [REG_W-1:0]   inDest,
  input  logic               inMemToReg,
  input  logic               inRegWrite,
  input  logic               inMemWrite,
  input  logic [OP_W-1:0]    inAluOp,
  output logic               stallFetch,
  output logic               stallDecode,
  output logic               flushExec,
  output logic [STAGE_W-1:0] fetchWord,
  output logic [STAGE_W-1:0] decodeWord,
  output logic [STAGE_W-1:0] execWord,
  output logic               memRegWrite,
  output logic               memMemWrite,
  output logic               wbRegWrite,
  output logic [REG_W-1:0]   wbDest
);

  stage_t  inStage;
  stage_t  fetchQ;
  stage_t  decQ;
  stage_t  exeQ;
  tail_t   memQ;
  tail_t   wbQ;
  strobe_t strobe;
  logic [NUM_SRC-1:0][REG_W-1:0] decSrc;

  always_comb begin
    inStage.srcA     = inSrcA;
    inStage.srcB     = inSrcB;
    inStage.dest     = inDest;
    inStage.memToReg = inMemToReg;
    inStage.regWrite = inRegWrite;
    inStage.memWrite = inMemWrite;
    inStage.aluOp    = inAluOp;
  end

  assign decSrc[0] = decQ.srcA;
  assign decSrc[1] = decQ.srcB;

  hzd_detect u_detect (
    .clk         (clk),
    .rst_n       (rst_n),
    .exeDest     (exeQ.dest),
    .exeMemToReg (exeQ.memToReg),
    .decSrc      (decSrc),
    .strobe      (strobe)
  );

  hzd_pipe_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .inStage (inStage),
    .strobe  (strobe),
    .fetchQ  (fetchQ),
    .decQ    (decQ),
    .exeQ    (exeQ),
    .memQ    (memQ),
    .wbQ     (wbQ)
  );

  assign stallFetch  = strobe.holdFetch;
  assign stallDecode = strobe.holdDecode;
  assign flushExec   = strobe.clearExec;
  assign fetchWord   = fetchQ;
  assign decodeWord  = decQ;
  assign execWord    = exeQ;
  assign memRegWrite = memQ.regWrite;
  assign memMemWrite = memQ.memWrite;
  assign wbRegWrite  = wbQ.regWrite;
  assign wbDest      = wbQ.dest;

endmodule

// File: tb/hzd_stall_top_tb.sv
module hzd_stall_top_tb;
  import hzd_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [STAGE_W-1:0] inWord = '0;
  logic stallFetch, stallDecode, flushExec;
  logic [STAGE_W-1:0] fetchWord, decodeWord, execWord;
  logic memRegWrite, memMemWrite, wbRegWrite;
  logic [REG_W-1:0] wbDest;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  hzd_stall_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .inSrcA(inWord[21:17]), .inSrcB(inWord[16:12]), .inDest(inWord[11:7]),
    .inMemToReg(inWord[6]), .inRegWrite(inWord[5]), .inMemWrite(inWord[4]),
    .inAluOp(inWord[3:0]),
    .stallFetch(stallFetch), .stallDecode(stallDecode), .flushExec(flushExec),
    .fetchWord(fetchWord), .decodeWord(decodeWord), .execWord(execWord),
    .memRegWrite(memRegWrite), .memMemWrite(memMemWrite),
    .wbRegWrite(wbRegWrite), .wbDest(wbDest)
  );

  // R11 layout: srcA[21:17] srcB[16:12] dest[11:7] m2r[6] rw[5] mw[4] op[3:0]
  function automatic logic [STAGE_W-1:0] mk(input int a, input int b, input int d,
                                            input bit m2r, input bit rw, input bit mw,
                                            input int op);
    return {a[4:0], b[4:0], d[4:0], m2r, rw, mw, op[3:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic drain();
    inWord = '0;
    repeat (5) tick();
  endtask

  task automatic tReset();
    chk(fetchWord == '0,  "R1 fetch",  fetchWord, 0);
    chk(decodeWord == '0, "R1 decode", decodeWord, 0);
    chk(execWord == '0,   "R1 exec",   execWord, 0);
    chk(!memRegWrite && !memMemWrite && !wbRegWrite && wbDest == '0,
        "R1 tail", {memRegWrite, memMemWrite, wbRegWrite, wbDest}, 0);
    chk({stallFetch, stallDecode, flushExec} == 3'b000, "R1 strobes",
        {stallFetch, stallDecode, flushExec}, 0);
  endtask

  // Full load-use sequence on srcA: R2, R6, R7, R8, R9
  task automatic tLoadUseFull();
    logic [STAGE_W-1:0] ld, dep, nxt, far;
    ld  = mk(1, 2, 5, 1, 1, 0, 3);
    dep = mk(5, 7, 8, 0, 1, 0, 1);
    nxt = mk(3, 4, 9, 0, 1, 0, 2);
    far = mk(6, 6, 10, 0, 1, 0, 4);
    inWord = ld;  tick();
    inWord = dep; tick();
    inWord = nxt; tick();
    chk({stallFetch, stallDecode, flushExec} == 3'b111, "R2 strobes",
        {stallFetch, stallDecode, flushExec}, 3'b111);
    inWord = far; tick();
    chk(fetchWord == nxt,  "R6 fetch held",  fetchWord, nxt);
    chk(decodeWord == dep, "R6 decode held", decodeWord, dep);
    chk(execWord == '0,    "R7 exec cleared", execWord, 0);
    chk(memRegWrite == 1'b1, "R9 load in memory", memRegWrite, 1);
    chk(stallDecode == 1'b0, "R9 stall dropped", stallDecode, 0);
    tick();
    chk(execWord == dep,   "R9 consumer in exec", execWord, dep);
    chk(wbRegWrite && wbDest == 5'd5, "R9 load in writeback",
        {wbRegWrite, wbDest}, {1'b1, 5'd5});
    chk(!memRegWrite && !memMemWrite, "R8 bubble in memory",
        {memRegWrite, memMemWrite}, 0);
    chk(decodeWord == nxt && fetchWord == far, "R6 resume order",
        {decodeWord, fetchWord}, {nxt, far});
    tick();
    chk(!wbRegWrite, "R8 bubble in writeback", wbRegWrite, 0);
    drain();
  endtask

  task automatic tPair(input logic [STAGE_W-1:0] prod, input logic [STAGE_W-1:0] cons,
                       input bit expStall, input string req);
    inWord = prod; tick();
    inWord = cons; tick();
    inWord = '0;   tick();
    chk(stallDecode == expStall && stallFetch == expStall && flushExec == expStall,
        req, {stallFetch, stallDecode, flushExec}, {3{expStall}});
    if (!expStall) begin
      tick();
      chk(execWord == cons, {req, " consumer advanced"}, execWord, cons);
    end
    drain();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tReset();
    tLoadUseFull();
    tPair(mk(1, 2, 6, 1, 1, 0, 3), mk(3, 6, 8, 0, 1, 0, 1), 1'b1, "R3 srcB match");
    tPair(mk(1, 2, 5, 0, 1, 0, 1), mk(5, 5, 8, 0, 1, 0, 1), 1'b0, "R4 alu producer");
    tPair(mk(1, 2, 0, 1, 1, 0, 3), mk(0, 0, 8, 0, 1, 0, 1), 1'b0, "R5 register zero");
    tPair(mk(1, 2, 5, 1, 1, 0, 3), mk(6, 7, 8, 0, 1, 0, 1), 1'b0, "R10 no match");
    tPair(mk(1, 2, 9, 1, 1, 0, 3), mk(9, 3, 4, 1, 1, 0, 3), 1'b1, "R2 load after load");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule